// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This unit sits on the CPU side of an interrupt path. An arbiter elsewhere has already chosen the winning source and checked it against the current mask level. It presents a request line and a source event code to this sequencer. The sequencer waits for the core to signal an instruction boundary. If the status register's block bit is clear at that moment, it performs the exception entry in one step.

On entry the sequencer captures four shadow values on a single clock edge:

- the event code;
- the status word;
- the program counter;
- the stack-pointer general register.

On that same edge it registers three values for the core:

- a new status word in which the block, privileged-mode and register-bank bits are forced to 1, while every other bit, the mask field included, is passed through unchanged;
- a handler address equal to the vector base plus 0x600;
- a one-cycle redirect strobe that tells fetch to flush and load that address.

The core is expected to load the new status word and program counter when the strobe is high. Instruction execution and the return path are handled elsewhere.

Top module: `irq_entry_seq`

## Requirements
- R1: An entry takes place only when `irq_req_i` and `insn_brk_i` are both 1 on a rising clock edge, the block bit of `sr_i` (bit 28) is 0 on that edge, and `take_o` is 0 on that edge.
- R2: `take_o` is 1 for exactly the one cycle that follows an accepting edge, and 0 otherwise.
- R3: On entry, `evt_o` takes the value `irq_code_i` had on the accepting edge.
- R4: On entry, `ssr_o` takes the value of `sr_i` and `spc_o` takes the value of `pc_i`, both sampled on the accepting edge.
- R5: On entry, `sgr_o` takes the value `sp_i` had on the accepting edge.
- R6: While `take_o` is 1, `sr_new_o` equals the sampled `sr_i` with bits 28 (block), 29 (register bank) and 30 (privileged mode) forced to 1. All other bits are unchanged, including the mask field at bits 7:4.
- R7: While `take_o` is 1, `pc_new_o` equals the sampled `vbr_i` plus 0x00000600, with the sum wrapped modulo 2^32.
- R8: A request that meets a boundary while the block bit of `sr_i` is 1 is ignored: `take_o` stays 0 and all shadow outputs keep their values.
- R9: A request that is present only in cycles without a boundary, and has been withdrawn by the time a boundary arrives, causes no entry.
- R10: While `rst_n` is low, `take_o`, `evt_o`, `ssr_o`, `spc_o`, `sgr_o`, `sr_new_o` and `pc_new_o` are all 0. Assertion of `rst_n` takes effect without waiting for a clock edge.
- R11: On the edge at which `take_o` is already 1, a request with a boundary is not accepted even if `sr_i` still shows the block bit clear.
- R12: In any cycle where `take_o` is 0, the four shadow outputs hold the values of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released through a two-stage synchronizer |
| irq_req_i | input | 1 | Interrupt request from the arbiter |
| irq_code_i | input | 12 | Event code of the requesting source |
| insn_brk_i | input | 1 | High in cycles that are a boundary between instructions |
| sr_i | input | 32 | Current status register |
| pc_i | input | 32 | Current program counter |
| sp_i | input | 32 | Current stack-pointer general register |
| vbr_i | input | 32 | Vector base register |
| take_o | output | 1 | One-cycle redirect strobe |
| pc_new_o | output | 32 | Handler address, valid with `take_o` |
| sr_new_o | output | 32 | Status word to load, valid with `take_o` |
| evt_o | output | 12 | Captured event code |
| ssr_o | output | 32 | Saved status register |
| spc_o | output | 32 | Saved program counter |
| sgr_o | output | 32 | Saved stack-pointer register |

## Verification
The bench holds a request with a boundary for two edges in a row. A design without the back-to-back guard would enter twice and overwrite the first event code. It also sets the block bit with a valid request and boundary present; a sequencer that ignored that bit would redirect and corrupt the saved state. A request withdrawn before the boundary arrives exposes a design that latches requests, because such a design would enter late. A vector base near the top of the address space checks that the handler address wraps. Status words carrying varied mask values show whether acceptance disturbs bits other than the three control bits.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  // Decision taken by the acceptance gate on each cycle.
  typedef enum logic [1:0] {
    GATE_IDLE  = 2'd0,   // no request
    GATE_WAIT  = 2'd1,   // request pending, no boundary yet
    GATE_BLOCK = 2'd2,   // boundary reached but entry inhibited
    GATE_TAKE  = 2'd3    // entry happens on this edge
  } gate_e;

endpackage

// File: rtl/irq_accept_gate.sv
module irq_accept_gate
  import irq_entry_pkg::*;
(
  input  logic  req_i,
  input  logic  brk_i,
  input  logic  blk_i,
  input  logic  busy_i,
  output gate_e decision_o
);

  always_comb begin
    if (!req_i) begin
      decision_o = GATE_IDLE;
    end else if (!brk_i) begin
      decision_o = GATE_WAIT;
    end else if (blk_i || busy_i) begin
      decision_o = GATE_BLOCK;
    end else begin
      decision_o = GATE_TAKE;
    end
  end

endmodule

// File: rtl/irq_sr_compose.sv
module irq_sr_compose #(
  parameter int unsigned W      = 32,
  parameter int unsigned BL_POS = 28,
  parameter int unsigned RB_POS = 29,
  parameter int unsigned MD_POS = 30
) (
  input  logic [W-1:0] sr_i,
  output logic [W-1:0] sr_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (b == BL_POS || b == RB_POS || b == MD_POS) begin : g_force
      assign sr_o[b] = 1'b1;
    end else begin : g_keep
      assign sr_o[b] = sr_i[b];
    end
  end

endmodule

// File: rtl/irq_shadow_reg.sv
module irq_shadow_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int unsigned W           = 32,
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned BL_POS      = 28,
  parameter int unsigned RB_POS      = 29,
  parameter int unsigned MD_POS      = 30,
  parameter logic [W-1:0] HANDLER_OFS = 'h600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req_i,
  input  logic [CODE_W-1:0] irq_code_i,
  input  logic              insn_brk_i,
  input  logic [W-1:0]      sr_i,
  input  logic [W-1:0]      pc_i,
  input  logic [W-1:0]      sp_i,
  input  logic [W-1:0]      vbr_i,
  output logic              take_o,
  output logic [W-1:0]      pc_new_o,
  output logic [W-1:0]      sr_new_o,
  output logic [CODE_W-1:0] evt_o,
  output logic [W-1:0]      ssr_o,
  output logic [W-1:0]      spc_o,
  output logic [W-1:0]      sgr_o
);

  localparam int unsigned SYNC_STAGES = 2;

  // Reset: asynchronous assertion, synchronous release.
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_int = rst_pipe[SYNC_STAGES-1];

  // Acceptance decision.
  gate_e decision;
  logic  accept;
  logic  take_q;
  logic  take_nxt;

  irq_accept_gate u_gate (
    .req_i      (irq_req_i),
    .brk_i      (insn_brk_i),
    .blk_i      (sr_i[BL_POS]),
    .busy_i     (take_q),
    .decision_o (decision)
  );

  assign accept = (decision == GATE_TAKE);

  // Redirect strobe: next-state and register.
  always_comb begin
    take_nxt = accept;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      take_q <= 1'b0;
    end else begin
      take_q <= take_nxt;
    end
  end

  assign take_o = take_q;

  // New status word and handler address.
  logic [W-1:0] sr_forced;
  logic [W-1:0] handler_pc;

  irq_sr_compose #(
    .W      (W),
    .BL_POS (BL_POS),
    .RB_POS (RB_POS),
    .MD_POS (MD_POS)
  ) u_sr_compose (
    .sr_i (sr_i),
    .sr_o (sr_forced)
  );

  assign handler_pc = vbr_i + HANDLER_OFS;

  // All state is captured on the same accepting edge.
  irq_shadow_reg #(.W(CODE_W)) u_evt (
    .clk (clk), .rst_n (rst_n_int), .en (accept), .d (irq_code_i), .q (evt_o)
  );

  irq_shadow_reg #(.W(W)) u_ssr (
    .clk (clk), .rst_n (rst_n_int), .en (accept), .d (sr_i), .q (ssr_o)
  );

  irq_shadow_reg #(.W(W)) u_spc (
    .clk (clk), .rst_n (rst_n_int), .en (accept), .d (pc_i), .q (spc_o)
  );

  irq_shadow_reg #(.W(W)) u_sgr (
    .clk (clk), .rst_n (rst_n_int), .en (accept), .d (sp_i), .q (sgr_o)
  );

  irq_shadow_reg #(.W(W)) u_srnew (
    .clk (clk), .rst_n (rst_n_int), .en (accept), .d (sr_forced), .q (sr_new_o)
  );

  irq_shadow_reg #(.W(W)) u_pcnew (
    .clk (clk), .rst_n (rst_n_int), .en (accept), .d (handler_pc), .q (pc_new_o)
  );

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int unsigned W           = 32,
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned BL_POS      = 28,
  parameter int unsigned RB_POS      = 29,
  parameter int unsigned MD_POS      = 30,
  parameter logic [W-1:0] HANDLER_OFS = 'h600
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_req_i,
  input logic [CODE_W-1:0] irq_code_i,
  input logic              insn_brk_i,
  input logic [W-1:0]      sr_i,
  input logic [W-1:0]      pc_i,
  input logic [W-1:0]      sp_i,
  input logic [W-1:0]      vbr_i,
  input logic              take_o,
  input logic [W-1:0]      pc_new_o,
  input logic [W-1:0]      sr_new_o,
  input logic [CODE_W-1:0] evt_o,
  input logic [W-1:0]      ssr_o,
  input logic [W-1:0]      spc_o,
  input logic [W-1:0]      sgr_o
);

  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] CTRL = (ONE << BL_POS) | (ONE << RB_POS) | (ONE << MD_POS);

  // R1
  take_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(irq_req_i && insn_brk_i && !sr_i[BL_POS] && !take_o));

  // R2
  take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> !take_o);

  // R3
  evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (evt_o == $past(irq_code_i)));

  // R4
  sr_pc_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (ssr_o == $past(sr_i) && spc_o == $past(pc_i)));

  // R5
  sp_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (sgr_o == $past(sp_i)));

  // R6
  sr_ctrl_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((sr_new_o & CTRL) == CTRL &&
                (sr_new_o & ~CTRL) == ($past(sr_i) & ~CTRL)));

  // R7
  handler_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (pc_new_o == $past(vbr_i) + HANDLER_OFS));

  // R8
  blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sr_i[BL_POS]) |-> !take_o);

  // R12
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> ($stable(evt_o) && $stable(ssr_o) && $stable(spc_o) && $stable(sgr_o)));

endmodule

bind irq_entry_seq irq_entry_chk #(
  .W           (W),
  .CODE_W      (CODE_W),
  .BL_POS      (BL_POS),
  .RB_POS      (RB_POS),
  .MD_POS      (MD_POS),
  .HANDLER_OFS (HANDLER_OFS)
) u_chk (.*);

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

  localparam logic [31:0] CTRL = 32'h7000_0000;
  localparam logic [31:0] OFS  = 32'h0000_0600;

  // {exp_take, req, brk, bl, code[11:0], vbr[31:0]}
  localparam logic [47:0] VEC [8] = '{
    {1'b1, 1'b1, 1'b1, 1'b0, 12'h200, 32'h8C00_0000},
    {1'b0, 1'b1, 1'b0, 1'b0, 12'h220, 32'h8C00_0000},
    {1'b0, 1'b0, 1'b1, 1'b0, 12'h230, 32'h8C00_0000},
    {1'b0, 1'b1, 1'b1, 1'b1, 12'h240, 32'h8C00_0000},
    {1'b1, 1'b1, 1'b1, 1'b0, 12'h3E0, 32'hFFFF_FC00},
    {1'b1, 1'b1, 1'b1, 1'b0, 12'hFFF, 32'h0000_0000},
    {1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 32'h1111_1111},
    {1'b1, 1'b1, 1'b1, 1'b0, 12'h5A0, 32'h1234_5678}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_req_i;
  logic [11:0] irq_code_i;
  logic        insn_brk_i;
  logic [31:0] sr_i, pc_i, sp_i, vbr_i;
  logic        take_o;
  logic [31:0] pc_new_o, sr_new_o, ssr_o, spc_o, sgr_o;
  logic [11:0] evt_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [11:0] m_evt;
  logic [31:0] m_ssr, m_spc, m_sgr;

  always #5 clk = ~clk;

  irq_entry_seq dut (
    .clk (clk), .rst_n (rst_n),
    .irq_req_i (irq_req_i), .irq_code_i (irq_code_i), .insn_brk_i (insn_brk_i),
    .sr_i (sr_i), .pc_i (pc_i), .sp_i (sp_i), .vbr_i (vbr_i),
    .take_o (take_o), .pc_new_o (pc_new_o), .sr_new_o (sr_new_o),
    .evt_o (evt_o), .ssr_o (ssr_o), .spc_o (spc_o), .sgr_o (sgr_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_shadows(input string tag);
    chk({tag, " evt"}, {20'd0, evt_o}, {20'd0, m_evt});
    chk({tag, " ssr"}, ssr_o, m_ssr);
    chk({tag, " spc"}, spc_o, m_spc);
    chk({tag, " sgr"}, sgr_o, m_sgr);
  endtask

  task automatic go_idle();
    irq_req_i  = 1'b0;
    insn_brk_i = 1'b0;
  endtask

  task automatic model_clear();
    m_evt = '0; m_ssr = '0; m_spc = '0; m_sgr = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    go_idle();
    irq_code_i = '0; sr_i = '0; pc_i = '0; sp_i = '0; vbr_i = '0;
    model_clear();
    repeat (3) @(negedge clk);

    // R10: reset state
    chk("R10 take", {31'd0, take_o}, 32'd0);
    chk_shadows("R10");
    chk("R10 sr_new", sr_new_o, 32'd0);
    chk("R10 pc_new", pc_new_o, 32'd0);

    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table: R1 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < 8; i++) begin
      logic [47:0] v;
      logic [31:0] sr_v;
      v    = VEC[i];
      sr_v = (32'h0300_0000 ^ (32'h0000_0011 * i)) & ~32'h1000_0000;
      if (v[44]) sr_v = sr_v | 32'h1000_0000;
      irq_req_i  = v[46];
      insn_brk_i = v[45];
      irq_code_i = v[43:32];
      vbr_i      = v[31:0];
      sr_i       = sr_v;
      pc_i       = 32'hA000_0000 + 32'(i * 4);
      sp_i       = 32'h8C00_1000 - 32'(i * 16);
      @(negedge clk);
      chk("R1/R8/R9 take", {31'd0, take_o}, {31'd0, v[47]});
      if (v[47]) begin
        m_evt = v[43:32]; m_ssr = sr_v; m_spc = pc_i; m_sgr = sp_i;
        chk("R6 sr_new", sr_new_o, sr_v | CTRL);
        chk("R7 pc_new", pc_new_o, v[31:0] + OFS);
      end
      chk_shadows("R3/R4/R5/R12 shadows");
      go_idle();
      @(negedge clk);
      chk("R2 take pulse", {31'd0, take_o}, 32'd0);
    end

    // R11: request with boundary held over two edges
    sr_i = 32'h0000_00A0; pc_i = 32'hA000_1000; sp_i = 32'h8C00_2000;
    vbr_i = 32'h8000_0000;
    irq_code_i = 12'h111; irq_req_i = 1'b1; insn_brk_i = 1'b1;
    @(negedge clk);
    chk("R11 first take", {31'd0, take_o}, 32'd1);
    m_evt = 12'h111; m_ssr = sr_i; m_spc = pc_i; m_sgr = sp_i;
    irq_code_i = 12'h222; pc_i = 32'hA000_2000;
    @(negedge clk);
    chk("R11 no second take", {31'd0, take_o}, 32'd0);
    chk_shadows("R11 shadows kept");
    go_idle();
    @(negedge clk);

    // R9: request withdrawn before boundary arrives
    irq_code_i = 12'h333; irq_req_i = 1'b1; insn_brk_i = 1'b0;
    repeat (2) @(negedge clk);
    irq_req_i = 1'b0; insn_brk_i = 1'b1;
    @(negedge clk);
    chk("R9 no late entry", {31'd0, take_o}, 32'd0);
    go_idle();
    @(negedge clk);
    chk("R9 still none", {31'd0, take_o}, 32'd0);
    chk_shadows("R9 shadows");

    // R10: asynchronous reset while the strobe is high
    irq_code_i = 12'h444; irq_req_i = 1'b1; insn_brk_i = 1'b1;
    @(negedge clk);
    chk("R10 pre-reset take", {31'd0, take_o}, 32'd1);
    go_idle();
    #1 rst_n = 1'b0;
    #1;
    model_clear();
    chk("R10 async take", {31'd0, take_o}, 32'd0);
    chk_shadows("R10 async");
    chk("R10 async pc_new", pc_new_o, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule